// File: doc/BRIEF.md
# USB Upstream Bus State Detector

This block watches the decoded line state of an upstream full-speed USB port and turns long bus conditions into sticky event flags. Two idle-duration detectors report "time to suspend" and "remote wake-up now allowed". A single-ended-zero duration detector reports a bus reset. A resume detector reports any non-idle line activity while the node is suspended. Two outside event pulses, end-of-packet and DMA, are also captured into the same event byte.

Software reads the event byte with a one-cycle read strobe. The read returns the byte and clears it. A software-written mask selects which event bits drive the single summary output `alt_evt`. Every duration is counted in cycles where `clk48_en` is high, and the thresholds are parameters so that a bench can shorten them. No interface of the block carries a data stream. All pins are plain control and status signals, and nothing applies back-pressure.

Top module: `usb_bus_state_monitor`

## Requirements
- R1: Line-state encoding is 2'b00 = SE0, 2'b01 = J/IDLE, 2'b10 = K, 2'b11 = illegal (non-idle). Bit 4 of `evt_rdata` becomes 1 after `IDLE_SHORT_CYC` enabled cycles of continuous IDLE. It fires once for each idle interval.
- R2: Bit 5 of `evt_rdata` becomes 1 after `IDLE_LONG_CYC` enabled cycles of continuous IDLE. It fires once for each idle interval.
- R3: Bit 6 of `evt_rdata` becomes 1 after `SE0_CYC` enabled cycles of continuous SE0. It fires once for each SE0 interval.
- R4: Bit 7 of `evt_rdata` becomes 1 on the first enabled cycle in which `node_suspended` is 1 and the line is not IDLE. It fires once until that condition ends. It never sets while `node_suspended` is 0.
- R5: In a cycle where `clk48_en` is 0, no duration counter advances and no resume is detected.
- R6: A pulse on `eop_pulse` sets bit 3 and a pulse on `dma_pulse` sets bit 2, one cycle later.
- R7: Bits 1:0 of `evt_rdata` and of `mask_rdata` always read 0. The mask is 0 after reset. `mask_wr` loads `mask_wdata` into the mask.
- R8: `evt_rd` clears every event bit on the next edge. An event that occurs in the same cycle as the read stays set.
- R9: `alt_evt` is 1 exactly when some bit is 1 in both `evt_rdata` and `mask_rdata`.
- R10: A duration count starts again from zero whenever the line leaves the state it qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk48_en | input | 1 | 48 MHz domain enable; counting and resume detection only when 1 |
| line_state | input | 2 | Decoded upstream line state |
| node_suspended | input | 1 | Node functional state is suspended |
| eop_pulse | input | 1 | End-of-packet event pulse |
| dma_pulse | input | 1 | DMA event pulse |
| evt_rd | input | 1 | Read strobe; clears the event byte |
| evt_rdata | output | 8 | Event byte: 7 resume, 6 reset, 5 long idle, 4 short idle, 3 EOP, 2 DMA |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | Mask write data |
| mask_rdata | output | 8 | Current mask |
| alt_evt | output | 1 | Masked summary of the event byte |

## Verification
The bench runs directed idle runs that stop one cycle short of each threshold and runs that reach it, to separate off-by-one counting from correct counting. Runs longer than the long threshold check that each flag fires only once. SE0 runs broken one cycle before the threshold show whether the count restarts or carries over. Activity while not suspended, while suspended, and with the enable low separates the suspend gating from the clock gating. Random line, enable, pulse, read and mask traffic is then compared every cycle against a bench model, which exposes lost same-cycle events and wrong mask bits.

// File: rtl/usb_bsm_pkg.sv
package usb_bsm_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_ILL = 2'b11
  } line_e;

  localparam int NUM_DET   = 4;
  localparam int DET_SHORT = 0;
  localparam int DET_LONG  = 1;
  localparam int DET_SE0   = 2;
  localparam int DET_RSM   = 3;

  localparam int BIT_DMA = 2;
  localparam int BIT_EOP = 3;
  localparam int BIT_SD_SHORT = 4;
  localparam int BIT_SD_LONG  = 5;
  localparam int BIT_BUSRST   = 6;
  localparam int BIT_RESUME   = 7;

  localparam logic [7:0] EVT_VALID = 8'hFC;
endpackage

// File: rtl/usb_bsm_dur_det.sv
module usb_bsm_dur_det #(
  parameter int THRESH = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qual,
  input  logic en,
  output logic fire
);
  localparam int CW = (THRESH < 2) ? 1 : $clog2(THRESH + 1);
  localparam logic [CW-1:0] LIMIT = CW'(THRESH);
  localparam logic [CW-1:0] LAST  = CW'(THRESH - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (!qual)                    cnt_q <= '0;
    else if (en && (cnt_q != LIMIT))   cnt_q <= cnt_q + 1'b1;
  end

  assign fire = qual && en && (cnt_q == LAST);
endmodule

// File: rtl/usb_bsm_evt_reg.sv
module usb_bsm_evt_reg
  import usb_bsm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] set_vec,
  input  logic       rd,
  input  logic       mask_wr,
  input  logic [7:0] mask_wdata,
  output logic [7:0] flags,
  output logic [7:0] mask,
  output logic       alt
);
  logic [7:0] flags_q, mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= ((rd ? 8'h00 : flags_q) | set_vec) & EVT_VALID;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_wdata & EVT_VALID;
  end

  assign flags = flags_q;
  assign mask  = mask_q;
  assign alt   = |(flags_q & mask_q);
endmodule

// File: rtl/usb_bus_state_monitor.sv
module usb_bus_state_monitor
  import usb_bsm_pkg::*;
#(
  parameter int IDLE_SHORT_CYC = 144000,
  parameter int IDLE_LONG_CYC  = 240000,
  parameter int SE0_CYC        = 120
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk48_en,
  input  logic [1:0] line_state,
  input  logic       node_suspended,
  input  logic       eop_pulse,
  input  logic       dma_pulse,
  input  logic       evt_rd,
  output logic [7:0] evt_rdata,
  input  logic       mask_wr,
  input  logic [7:0] mask_wdata,
  output logic [7:0] mask_rdata,
  output logic       alt_evt
);
  logic is_idle, is_se0;
  logic [NUM_DET-1:0] qual, fire;
  logic [7:0] set_vec;

  assign is_idle = (line_state == LS_J);
  assign is_se0  = (line_state == LS_SE0);

  assign qual[DET_SHORT] = is_idle;
  assign qual[DET_LONG]  = is_idle;
  assign qual[DET_SE0]   = is_se0;
  assign qual[DET_RSM]   = node_suspended && !is_idle;

  for (genvar g = 0; g < NUM_DET; g++) begin : g_det
    localparam int TH = (g == DET_SHORT) ? IDLE_SHORT_CYC :
                        (g == DET_LONG)  ? IDLE_LONG_CYC  :
                        (g == DET_SE0)   ? SE0_CYC        : 1;
    usb_bsm_dur_det #(.THRESH(TH)) u_det (
      .clk  (clk),
      .rst_n(rst_n),
      .qual (qual[g]),
      .en   (clk48_en),
      .fire (fire[g])
    );
  end

  always_comb begin
    set_vec               = '0;
    set_vec[BIT_DMA]      = dma_pulse;
    set_vec[BIT_EOP]      = eop_pulse;
    set_vec[BIT_SD_SHORT] = fire[DET_SHORT];
    set_vec[BIT_SD_LONG]  = fire[DET_LONG];
    set_vec[BIT_BUSRST]   = fire[DET_SE0];
    set_vec[BIT_RESUME]   = fire[DET_RSM];
  end

  usb_bsm_evt_reg u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .rd        (evt_rd),
    .mask_wr   (mask_wr),
    .mask_wdata(mask_wdata),
    .flags     (evt_rdata),
    .mask      (mask_rdata),
    .alt       (alt_evt)
  );
endmodule

// File: rtl/usb_bsm_checker.sv
module usb_bsm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       clk48_en,
  input logic [1:0] line_state,
  input logic       node_suspended,
  input logic       eop_pulse,
  input logic       evt_rd,
  input logic [7:0] evt_rdata,
  input logic [7:0] mask_rdata,
  input logic       alt_evt
);
  AST_RSV_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rdata[1:0] == 2'b00) && (mask_rdata[1:0] == 2'b00)); // R7

  AST_SHORT_IDLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_rdata[4]) |-> ($past(line_state) == 2'b01) && $past(clk48_en)); // R1

  AST_LONG_IDLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_rdata[5]) |-> ($past(line_state) == 2'b01) && $past(clk48_en)); // R2

  AST_BUSRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_rdata[6]) |-> ($past(line_state) == 2'b00) && $past(clk48_en)); // R3

  AST_RESUME_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_rdata[7]) |-> $past(node_suspended) && $past(clk48_en)
                            && ($past(line_state) != 2'b01)); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd |=> (evt_rdata[3] == $past(eop_pulse))); // R8

  AST_SUMMARY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    alt_evt == ((evt_rdata & mask_rdata) != 8'h00)); // R9
endmodule

bind usb_bus_state_monitor usb_bsm_checker u_bsm_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clk48_en      (clk48_en),
  .line_state    (line_state),
  .node_suspended(node_suspended),
  .eop_pulse     (eop_pulse),
  .evt_rd        (evt_rd),
  .evt_rdata     (evt_rdata),
  .mask_rdata    (mask_rdata),
  .alt_evt       (alt_evt)
);

// File: tb/usb_bus_state_monitor_bench.sv
module usb_bus_state_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TH_S   = 30;
  localparam int TH_L   = 50;
  localparam int TH_SE0 = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk48_en = 1'b1;
  logic [1:0] line_state = 2'b10;
  logic       node_suspended = 1'b0;
  logic       eop_pulse = 1'b0;
  logic       dma_pulse = 1'b0;
  logic       evt_rd = 1'b0;
  logic       mask_wr = 1'b0;
  logic [7:0] mask_wdata = 8'h00;
  logic [7:0] evt_rdata, mask_rdata;
  logic       alt_evt;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_bus_state_monitor #(
    .IDLE_SHORT_CYC(TH_S), .IDLE_LONG_CYC(TH_L), .SE0_CYC(TH_SE0)
  ) u_usb_bus_state_monitor (
    .clk(clk), .rst_n(rst_n), .clk48_en(clk48_en), .line_state(line_state),
    .node_suspended(node_suspended), .eop_pulse(eop_pulse), .dma_pulse(dma_pulse),
    .evt_rd(evt_rd), .evt_rdata(evt_rdata), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .mask_rdata(mask_rdata), .alt_evt(alt_evt)
  );

  // Behavioural model built from the requirements
  int m_idle = 0, m_se0 = 0, m_rsm = 0;
  logic [7:0] m_flags = 8'h00, m_mask = 8'h00;

  always @(posedge clk) begin
    logic [7:0] ev;
    ev = 8'h00;
    if (!rst_n) begin
      m_idle = 0; m_se0 = 0; m_rsm = 0; m_flags = 8'h00; m_mask = 8'h00;
    end else begin
      if (line_state == 2'b01) begin
        if (clk48_en && m_idle < TH_L) begin
          m_idle++;
          if (m_idle == TH_S) ev[4] = 1'b1;
          if (m_idle == TH_L) ev[5] = 1'b1;
        end
      end else m_idle = 0;
      if (line_state == 2'b00) begin
        if (clk48_en && m_se0 < TH_SE0) begin
          m_se0++;
          if (m_se0 == TH_SE0) ev[6] = 1'b1;
        end
      end else m_se0 = 0;
      if (node_suspended && line_state != 2'b01) begin
        if (clk48_en && m_rsm == 0) begin m_rsm = 1; ev[7] = 1'b1; end
      end else m_rsm = 0;
      ev[3] = eop_pulse;
      ev[2] = dma_pulse;
      m_flags = (evt_rd ? 8'h00 : m_flags) | ev;
      if (mask_wr) m_mask = mask_wdata & 8'hFC;
    end
  end

  function automatic string req_of_bit(input int b);
    case (b)
      7: return "R4";
      6: return "R3";
      5: return "R2";
      4: return "R1";
      3, 2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model(input string tag);
    logic [7:0] d;
    n_vec++;
    d = evt_rdata ^ m_flags;
    if (d != 8'h00 || mask_rdata !== m_mask || alt_evt !== |(m_flags & m_mask)) begin
      n_bad++;
      for (int b = 7; b >= 0; b--)
        if (d[b]) begin tag = {tag, " ", req_of_bit(b)}; break; end
      if (d == 8'h00 && mask_rdata !== m_mask) tag = {tag, " R7"};
      if (d == 8'h00 && mask_rdata === m_mask) tag = {tag, " R9"};
      $display("FAIL %s actual evt=%h mask=%h alt=%b expected evt=%h mask=%h alt=%b",
               tag, evt_rdata, mask_rdata, alt_evt, m_flags, m_mask, |(m_flags & m_mask));
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin cyc(); cmp_model(tag); end
  endtask

  task automatic do_read();
    evt_rd = 1'b1; cyc(); evt_rd = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd7);
    repeat (3) cyc();
    rst_n = 1'b1;
    // R7 reset state
    chk("R7 evt after reset", evt_rdata, 8'h00);
    chk("R7 mask after reset", mask_rdata, 8'h00);
    chk("R9 alt after reset", alt_evt, 1'b0);

    // R1/R2: idle thresholds
    line_state = 2'b01;
    run(TH_S - 1, "R1 pre");
    chk("R1 not yet", evt_rdata[4], 1'b0);
    cyc(); cmp_model("R1");
    chk("R1 short idle set", evt_rdata[4], 1'b1);
    run(TH_L - TH_S - 1, "R2 pre");
    chk("R2 not yet", evt_rdata[5], 1'b0);
    cyc();
    chk("R2 long idle set", evt_rdata[5], 1'b1);
    do_read(); cmp_model("R8");
    chk("R8 cleared", evt_rdata, 8'h00);
    run(TH_L, "R1 once");
    chk("R1 R2 no refire", evt_rdata, 8'h00);

    // R3 / R10: SE0 broken one short, then complete
    line_state = 2'b00;
    run(TH_SE0 - 1, "R10 pre");
    line_state = 2'b10; cyc();
    line_state = 2'b00;
    run(TH_SE0 - 1, "R10");
    chk("R10 restart no reset flag", evt_rdata[6], 1'b0);
    cyc(); cmp_model("R3");
    chk("R3 bus reset set", evt_rdata[6], 1'b1);

    // R9 masking
    mask_wdata = 8'hFF; mask_wr = 1'b1; cyc(); mask_wr = 1'b0;
    chk("R7 mask reserved", mask_rdata, 8'hFC);
    chk("R9 alt on", alt_evt, 1'b1);
    mask_wdata = 8'h80; mask_wr = 1'b1; cyc(); mask_wr = 1'b0;
    chk("R9 alt off", alt_evt, 1'b0);
    do_read();

    // R4: activity not suspended -> no resume
    line_state = 2'b10; run(4, "R4 unsusp");
    chk("R4 no resume unsuspended", evt_rdata[7], 1'b0);
    // R5: suspended but enable off
    line_state = 2'b01; cyc();
    node_suspended = 1'b1; clk48_en = 1'b0; line_state = 2'b10;
    run(3, "R5");
    chk("R5 no resume when disabled", evt_rdata[7], 1'b0);
    clk48_en = 1'b1; cyc(); cmp_model("R4");
    chk("R4 resume set", evt_rdata[7], 1'b1);
    chk("R9 alt resume masked", alt_evt, 1'b1);

    // R8: event in same cycle as read survives
    eop_pulse = 1'b1; evt_rd = 1'b1; cyc(); eop_pulse = 1'b0; evt_rd = 1'b0;
    chk("R8 R6 same-cycle event kept", evt_rdata, 8'h08);
    dma_pulse = 1'b1; cyc(); dma_pulse = 1'b0;
    chk("R6 dma set", evt_rdata, 8'h0C);
    do_read();
    node_suspended = 1'b0;

    // Random phase
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 6) line_state = 2'($urandom_range(0, 3));
      else if (r < 8) line_state = 2'b01;
      clk48_en       = ($urandom_range(0, 9) != 0);
      node_suspended = ($urandom_range(0, 199) == 0) ? ~node_suspended : node_suspended;
      eop_pulse      = ($urandom_range(0, 29) == 0);
      dma_pulse      = ($urandom_range(0, 29) == 0);
      evt_rd         = ($urandom_range(0, 24) == 0);
      mask_wr        = ($urandom_range(0, 49) == 0);
      mask_wdata     = 8'($urandom());
      cyc();
      cmp_model("random");
    end
    eop_pulse = 0; dma_pulse = 0; evt_rd = 0; mask_wr = 0;
    finished = 1;
    summary();
    $finish;
  end
endmodule